// File: doc/BRIEF.md
# Differential Piezo Tone Generator

The block drives a piezo buzzer with two complementary square waves, `bz_p` and `bz_n`. Both come from a single-cycle 32 kHz tick that is divided down. Three command strobes control it. One starts a 4 kHz tone and one starts a 2 kHz tone; each of these also switches the tone on. The third switches the tone off. A level input, `sys_en`, reflects the global system-enable state. While it is low, both outputs sit low and the divider is frozen. When it returns, the tone carries on from where it stopped.

A three-state controller tracks the tone:

- `TONE_OFF` is the reset state; the tone is silent.
- `TONE_RUN` means the tone is on and the system is enabled.
- `TONE_HOLD` means the tone is on but the system is disabled.

Transitions:

- start (`TONE_OFF` to `TONE_RUN` or `TONE_HOLD`, by `sys_en`) on a tone command with no off command.
- suspend (`TONE_RUN` to `TONE_HOLD`) when `sys_en` is low.
- resume (`TONE_HOLD` to `TONE_RUN`) when `sys_en` is high.
- stop (`TONE_RUN` or `TONE_HOLD` to `TONE_OFF`) on the off command.

A half-period divider owns the phase and the active frequency. A small drive stage forms the output pair.

Top module: `buzz_tone_gen`

## Requirements
- R1: After reset the tone is off and `{bz_p,bz_n}` is `00`.
- R2: A 4 kHz command taken while the tone is off starts the tone. In the cycle after the command edge, `bz_p`=1 and `bz_n`=0. Each half-period then lasts 4 ticks.
- R3: A 2 kHz command taken while the tone is off starts the tone in the same way, with half-periods of 8 ticks.
- R4: While the tone is on and `sys_en`=1, exactly one of `bz_p`/`bz_n` is high. The two swap after every completed half-period.
- R5: The off command silences the tone: `{bz_p,bz_n}`=`00` from the cycle after its edge. When strobes arrive together, off beats both tone commands, and 2 kHz beats 4 kHz.
- R6: While `sys_en`=0, both outputs are low in that same cycle. Ticks are not counted. When `sys_en` returns, the tone resumes with the same phase and count.
- R7: A tone command while the tone is on does not cut short the half-period in progress. The new frequency takes effect from the next swap of the pair.
- R8: A tone command while the tone is on does not restart the divider. The current phase and count continue.
- R9: On start the divider is cleared. A tick in the start cycle is ignored, so the first half-period has its full length in ticks.
- R10: Without a tick, the pair never swaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 32 kHz time-base enable |
| sys_en | input | 1 | Global system enable level; 0 forces silence and freezes the divider |
| cmd_off | input | 1 | Strobe: turn the tone off |
| cmd_4k | input | 1 | Strobe: select 4 kHz and turn the tone on |
| cmd_2k | input | 1 | Strobe: select 2 kHz and turn the tone on |
| bz_p | output | 1 | Buzzer output, high in the first half-period |
| bz_n | output | 1 | Complementary buzzer output |

## Verification
A wrong controller state shows at the pins within one clock. A tone that fails to stop keeps the pair moving after the off strobe. A missed start leaves it at `00` where `10` is due. Divider errors take longer to appear, up to one half-period (8 ticks, 32 clocks here), as a swap that comes early or late. A stale frequency selection shows as a half-period of the wrong length right after the first swap that follows a change. The bench therefore compares the pair in every cycle against a model kept from the requirements, so a timing shift of even one clock is caught.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    typedef enum logic [1:0] {
        TONE_OFF  = 2'd0,
        TONE_RUN  = 2'd1,
        TONE_HOLD = 2'd2
    } tone_state_e;

    typedef enum logic {
        SEL_4K = 1'b0,
        SEL_2K = 1'b1
    } tone_sel_e;

endpackage

// File: rtl/buzz_ctrl.sv
module buzz_ctrl
    import buzz_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_en,
    input  logic        cmd_off,
    input  logic        cmd_4k,
    input  logic        cmd_2k,
    output tone_state_e state_o,
    output logic        start_o,
    output tone_sel_e   sel_next_o,
    output logic        run_en_o
);

    tone_state_e state_q, state_d;
    tone_sel_e   pend_q, pend_d;
    logic        tone_req;

    assign tone_req = cmd_4k | cmd_2k;

    // 2 kHz wins over 4 kHz when both strobes arrive together
    always_comb begin
        if (cmd_2k)      pend_d = SEL_2K;
        else if (cmd_4k) pend_d = SEL_4K;
        else             pend_d = pend_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TONE_OFF: begin
                if (!cmd_off && tone_req)
                    state_d = sys_en ? TONE_RUN : TONE_HOLD;
            end
            TONE_RUN: begin
                if (cmd_off)      state_d = TONE_OFF;
                else if (!sys_en) state_d = TONE_HOLD;
            end
            TONE_HOLD: begin
                if (cmd_off)     state_d = TONE_OFF;
                else if (sys_en) state_d = TONE_RUN;
            end
            default: state_d = TONE_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TONE_OFF;
            pend_q  <= SEL_4K;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        sel_next_o = pend_d;
        start_o    = (state_q == TONE_OFF) && tone_req && !cmd_off;
        run_en_o   = (state_q != TONE_OFF) && sys_en;
    end

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> (state_q == TONE_OFF)); // R5

    AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != TONE_OFF) && !cmd_off && !sys_en) |=> (state_q == TONE_HOLD)); // R6

    AST_START_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TONE_OFF) && tone_req && !cmd_off) |=> (state_q != TONE_OFF)); // R2

endmodule

// File: rtl/buzz_div.sv
module buzz_div
    import buzz_pkg::*;
#(
    parameter int HALF_4K = 4,
    parameter int HALF_2K = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  tone_sel_e sel_next,
    input  logic      run_en,
    input  logic      tick,
    output logic      phase_o
);

    localparam int HMAX = (HALF_2K > HALF_4K) ? HALF_2K : HALF_4K;
    localparam int CW   = (HMAX < 2) ? 1 : $clog2(HMAX);
    localparam logic [CW-1:0] LIM_4K = CW'(HALF_4K - 1);
    localparam logic [CW-1:0] LIM_2K = CW'(HALF_2K - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          phase_q;
    tone_sel_e     act_q;
    logic          at_end;

    always_comb begin
        lim    = (act_q == SEL_2K) ? LIM_2K : LIM_4K;
        at_end = (cnt_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
            act_q   <= SEL_4K;
        end else if (start) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
            act_q   <= sel_next;
        end else if (run_en && tick) begin
            if (at_end) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
                act_q   <= sel_next;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim); // R3

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !start) |=> ($stable(cnt_q) && $stable(phase_q))); // R6

    AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((cnt_q == '0) && phase_q)); // R9

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(phase_q)); // R10

endmodule

// File: rtl/buzz_drive.sv
module buzz_drive (
    input  logic enable,
    input  logic phase,
    output logic out_p,
    output logic out_n
);

    always_comb begin
        out_p = enable &  phase;
        out_n = enable & ~phase;
    end

endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
    import buzz_pkg::*;
#(
    parameter int HALF_4K = 4,
    parameter int HALF_2K = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sys_en,
    input  logic cmd_off,
    input  logic cmd_4k,
    input  logic cmd_2k,
    output logic bz_p,
    output logic bz_n
);

    tone_state_e state;
    tone_sel_e   sel_next;
    logic        start;
    logic        run_en;
    logic        phase;

    buzz_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_en     (sys_en),
        .cmd_off    (cmd_off),
        .cmd_4k     (cmd_4k),
        .cmd_2k     (cmd_2k),
        .state_o    (state),
        .start_o    (start),
        .sel_next_o (sel_next),
        .run_en_o   (run_en)
    );

    buzz_div #(
        .HALF_4K (HALF_4K),
        .HALF_2K (HALF_2K)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sel_next (sel_next),
        .run_en   (run_en),
        .tick     (tick),
        .phase_o  (phase)
    );

    buzz_drive u_drive (
        .enable (run_en),
        .phase  (phase),
        .out_p  (bz_p),
        .out_n  (bz_n)
    );

    AST_PAIR_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != TONE_OFF) && sys_en) |-> (bz_p != bz_n)); // R4

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en |-> (!bz_p && !bz_n)); // R6

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> (!bz_p && !bz_n)); // R5

    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sys_en) |=> (sys_en -> (bz_p && !bz_n))); // R2

endmodule

// File: tb/tb_buzz_tone_gen.sv
module tb_buzz_tone_gen;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sys_en = 1'b1;
    logic cmd_off = 1'b0;
    logic cmd_4k = 1'b0;
    logic cmd_2k = 1'b0;
    logic bz_p, bz_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    buzz_tone_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sys_en  (sys_en),
        .cmd_off (cmd_off),
        .cmd_4k  (cmd_4k),
        .cmd_2k  (cmd_2k),
        .bz_p    (bz_p),
        .bz_n    (bz_n)
    );

    logic [1:0] exp_q[$];
    string      tag_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state, kept from the requirements
    bit m_on = 0;
    bit m_sel = 0;   // 0: 4 kHz (4 ticks), 1: 2 kHz (8 ticks)
    bit m_pend = 0;
    int m_cnt = 0;
    bit m_ph = 1;

    task automatic drive(bit off, bit c4, bit c2, bit se, string tag);
        bit tk;
        @(negedge clk);
        tk = (cyc % 4 == 0);
        cyc++;
        tick = tk; sys_en = se; cmd_off = off; cmd_4k = c4; cmd_2k = c2;
        if (off) begin
            m_on = 0;
        end else if ((c4 || c2) && !m_on) begin
            m_on = 1; m_sel = c2; m_pend = c2; m_cnt = 0; m_ph = 1;
        end else begin
            if (c2) m_pend = 1;
            else if (c4) m_pend = 0;
            if (m_on && se && tk) begin
                if (m_cnt == (m_sel ? 8 : 4) - 1) begin
                    m_cnt = 0; m_ph = !m_ph; m_sel = m_pend;
                end else begin
                    m_cnt++;
                end
            end
        end
        exp_q.push_back((m_on && se) ? {m_ph, !m_ph} : 2'b00);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n, bit se, string tag);
        for (int i = 0; i < n; i++) drive(0, 0, 0, se, tag);
    endtask

    // advance so the next driven cycle carries a tick (want=1) or not (want=0)
    task automatic align(bit want, string tag);
        while ((cyc % 4 == 0) != want) drive(0, 0, 0, 1, tag);
    endtask

    // monitor: pops one expected item per cycle, after the edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({bz_p, bz_n} !== e) begin
                    errors++;
                    $display("FAIL %s: {bz_p,bz_n} got %b expected %b (cycle %0d)", t, {bz_p, bz_n}, e, cyc);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({bz_p, bz_n} !== 2'b00) begin
            errors++;
            $display("FAIL R1: reset pair got %b expected 00", {bz_p, bz_n});
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(10, 1, "R1 idle after reset");

        // 4 kHz start on a non-tick cycle
        align(0, "R2 align");
        drive(0, 1, 0, 1, "R2 start 4k");
        idle(70, 1, "R2/R4 4k run");

        // change to 2 kHz mid half-period, then back to 4 kHz
        drive(0, 0, 1, 1, "R7/R8 switch to 2k");
        idle(100, 1, "R7 2k run");
        drive(0, 1, 0, 1, "R7/R8 switch to 4k");
        idle(60, 1, "R7 back to 4k");

        // system disable freezes and silences
        idle(2, 1, "R6 pre");
        idle(23, 0, "R6 disabled");
        idle(40, 1, "R6 resume");

        // off
        drive(1, 0, 0, 1, "R5 off");
        idle(20, 1, "R5 silent");
        idle(12, 1, "R10 no tone idle");

        // off beats a simultaneous tone command
        drive(1, 1, 1, 1, "R5 off wins");
        idle(12, 1, "R5 stays silent");

        // 2 kHz beats 4 kHz, start on a tick cycle
        align(1, "R9 align");
        drive(0, 1, 1, 1, "R5/R9 2k wins, tick ignored");
        idle(90, 1, "R3 2k run");

        // restart while running does not reset divider
        idle(3, 1, "R8 pre");
        drive(0, 0, 1, 1, "R8 same 2k again");
        idle(40, 1, "R8 continue");
        drive(1, 0, 0, 1, "R5 off running");
        idle(6, 1, "R5 silent");

        // start while the system is disabled
        drive(0, 1, 0, 0, "R6 start while disabled");
        idle(10, 0, "R6 held silent");
        idle(40, 1, "R2/R6 first half after enable");
        drive(1, 0, 0, 0, "R5 off while disabled");
        idle(8, 1, "R5 silent after enable");

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule